// File: doc/BRIEF.md
# UART Request-to-Send Pin Control

This block owns the request-to-send bit of a UART's modem control register. It drives the active-low `rts_n` pin from that bit. Software reaches the bit through a 32-bit register port at two addresses. One is the full modem control word, where the bit sits at position 1. The other is a one-bit alias at position 0, which lets software set or clear the bit with a single write and no read-modify-write. Both addresses hit the same storage flop.

The pin is driven by a small state machine. Its states are named as follows:

- `ST_OFF`: the bit is clear, so the pin is high.
- `ST_ON`: the bit is set and nothing gates it, so the pin is low.
- `ST_THROTTLE`: the bit is set, but the receive FIFO is too full in automatic flow control, so the pin is high.
- `ST_LOOP`: loopback, so the pin is held high.

Transitions are evaluated every cycle in this priority:

- Loopback selects `ST_LOOP`.
- Otherwise a clear bit selects `ST_OFF`.
- Otherwise automatic gating with the FIFO over its trigger selects `ST_THROTTLE`.
- Otherwise `ST_ON` is selected.

Every state can reach every other state in one cycle. The pin comes from a flop loaded with the next-state decode, so it changes exactly one clock after its inputs and never glitches.

Automatic gating needs both the auto-flow enable and the FIFO enable. A select input picks the trigger:

- Select low: the programmed threshold. The FIFO counts as over when the level exceeds the threshold.
- Select high: almost-full. The FIFO counts as over when the level is at or above `DEPTH-2`, that is, two or fewer free slots.

In loopback the bit value is returned combinationally on `loop_cts`, for use as the internal clear-to-send input.

Top module: `rts_flow_ctrl`

## Requirements
- R1: A write to the alias address (default 0x24) loads `reg_wdata[0]` into the RTS bit. A read of the alias returns the bit at position 0, and a read of the control word address (default 0x10) returns it at position 1.
- R2: A write to the control word address loads `reg_wdata[1]` into the same RTS bit that the alias reads.
- R3: On an alias read, bits 31:1 are zero, and writes to those bits have no effect. On a control word read, every bit other than bit 1 is zero. Reads of any other address return zero.
- R4: While reset is asserted, and on leaving reset, the RTS bit is 0, `rts_n` is 1 and `loop_cts` is 0.
- R5: Outside loopback, and with automatic gating inactive, `rts_n` is the inverse of the RTS bit.
- R6: With auto-flow enable, FIFO enable and select all low-select (select = 0), and the RTS bit set, `rts_n` is 1 while `rx_level > rx_thresh` and 0 otherwise.
- R7: With auto-flow enable, FIFO enable and select = 1, and the RTS bit set, `rts_n` is 1 while `rx_level >= DEPTH-2` and 0 otherwise.
- R8: With auto-flow enable set but FIFO enable clear, `rx_level` has no effect on `rts_n`.
- R9: With `loop_en` = 1, `rts_n` is 1 regardless of every other input, and `loop_cts` equals the RTS bit. With `loop_en` = 0, `loop_cts` is 0.
- R10: `rts_n` reflects the RTS bit and the inputs as they stood before the previous rising clock edge, so it has one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| auto_flow_en | input | 1 | Automatic flow control enable |
| fifo_en | input | 1 | FIFO enable |
| trig_sel | input | 1 | 0: programmed threshold, 1: almost-full trigger |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_thresh | input | LVL_W | Programmed receive threshold level |
| loop_en | input | 1 | Loopback mode |
| rts_n | output | 1 | Request-to-send pin, active low |
| loop_cts | output | 1 | Looped-back RTS value for the modem-status path |

## Verification
The hardest state to reach is `ST_THROTTLE` at the exact boundary of each trigger. At those levels a single count separates the pin being driven from it being released. The stimulus holds the RTS bit set with gating on and sweeps `rx_level` through every value from 0 to `DEPTH`, both upward and downward. It repeats the sweep once for each trigger select, with a threshold chosen away from `DEPTH-2` so that the two triggers disagree at several levels. It then clears the FIFO enable while the level is full, and raises loopback on top of a throttled state, to prove each override by the pin value alone.

// File: rtl/rts_flow_pkg.sv
package rts_flow_pkg;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_ON       = 2'd1,
        ST_THROTTLE = 2'd2,
        ST_LOOP     = 2'd3
    } rts_state_e;

    localparam int unsigned REG_W = 32;

endpackage

// File: rtl/rts_regs.sv
module rts_regs
    import rts_flow_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] MCR_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] SHD_OFS = 8'h24,
    parameter int unsigned       RTS_POS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic              rts_o,
    output logic [REG_W-1:0]  rdata_o
);

    logic rts_q;
    logic hit_shd;
    logic hit_mcr;

    assign hit_shd = (addr_i == SHD_OFS);
    assign hit_mcr = (addr_i == MCR_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rts_q <= 1'b0;
        end else if (wr_i && hit_shd) begin
            rts_q <= wdata_i[0];
        end else if (wr_i && hit_mcr) begin
            rts_q <= wdata_i[RTS_POS];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit_shd) begin
            rdata_o[0] = rts_q;
        end else if (hit_mcr) begin
            rdata_o[RTS_POS] = rts_q;
        end
    end

    assign rts_o = rts_q;

    // R1: an alias write lands in the bit
    p_shadow_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_i) && $past(addr_i) == SHD_OFS)
            |-> (rts_q == $past(wdata_i[0])));

    // R2: a control word write lands in the same bit
    p_mcr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_i) && $past(addr_i) == MCR_OFS)
            |-> (rts_q == $past(wdata_i[RTS_POS])));

    // R3: alias read leaves the upper bits clear
    p_shadow_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_shd |-> (rdata_o[REG_W-1:1] == '0));

    // R1: the bit holds without a write
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_i)) |-> $stable(rts_q));

endmodule

// File: rtl/rts_trigger.sv
module rts_trigger #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             auto_en_i,
    input  logic             fifo_en_i,
    input  logic             sel_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] thresh_i,
    output logic             gate_o,
    output logic             over_o
);

    logic over_thr;
    logic over_af;

    generate
        if (DEPTH > 2) begin : g_af
            localparam logic [LVL_W-1:0] AF_LVL = LVL_W'(DEPTH - 2);
            assign over_af = (level_i >= AF_LVL);
        end else begin : g_af_small
            assign over_af = 1'b1;
        end
    endgenerate

    assign over_thr = (level_i > thresh_i);
    assign gate_o   = auto_en_i & fifo_en_i;
    assign over_o   = sel_i ? over_af : over_thr;

endmodule

// File: rtl/rts_pin_fsm.sv
module rts_pin_fsm
    import rts_flow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loop_i,
    input  logic rts_i,
    input  logic gate_i,
    input  logic over_i,
    output logic rts_n_o
);

    rts_state_e state_q;
    rts_state_e state_d;
    logic       pin_q;

    always_comb begin
        state_d = ST_OFF;
        if (loop_i) begin
            state_d = ST_LOOP;
        end else if (!rts_i) begin
            state_d = ST_OFF;
        end else if (gate_i && over_i) begin
            state_d = ST_THROTTLE;
        end else begin
            state_d = ST_ON;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
        end else begin
            unique case (state_d)
                ST_ON:       pin_q <= 1'b0;
                ST_OFF:      pin_q <= 1'b1;
                ST_THROTTLE: pin_q <= 1'b1;
                ST_LOOP:     pin_q <= 1'b1;
                default:     pin_q <= 1'b1;
            endcase
        end
    end

    assign rts_n_o = pin_q;

    // R9: loopback forces the pin high
    p_loop_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(loop_i) |-> rts_n_o);

    // R5: a clear bit leaves the pin high
    p_off_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rts_i) |-> rts_n_o);

    // R6: gated and over trigger releases the pin
    p_throttle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rts_i && gate_i && over_i) |-> rts_n_o);

    // R10: a set, ungated bit drives the pin low one cycle on
    p_drive_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rts_i && !loop_i && !(gate_i && over_i)))
            |-> !rts_n_o);

    // R4: the state and the pin agree on the driven state
    p_state_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON) == !rts_n_o);

endmodule

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl
    import rts_flow_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned MCR_OFS = 8'h10,
    parameter int unsigned SHD_OFS = 8'h24,
    localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              auto_flow_en,
    input  logic              fifo_en,
    input  logic              trig_sel,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  rx_thresh,
    input  logic              loop_en,
    output logic              rts_n,
    output logic              loop_cts
);

    logic rts_bit;
    logic gate;
    logic over;

    rts_regs #(
        .ADDR_W  (ADDR_W),
        .MCR_OFS (ADDR_W'(MCR_OFS)),
        .SHD_OFS (ADDR_W'(SHD_OFS)),
        .RTS_POS (1)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rts_o   (rts_bit),
        .rdata_o (reg_rdata)
    );

    rts_trigger #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) u_trig (
        .auto_en_i (auto_flow_en),
        .fifo_en_i (fifo_en),
        .sel_i     (trig_sel),
        .level_i   (rx_level),
        .thresh_i  (rx_thresh),
        .gate_o    (gate),
        .over_o    (over)
    );

    rts_pin_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .loop_i  (loop_en),
        .rts_i   (rts_bit),
        .gate_i  (gate),
        .over_i  (over),
        .rts_n_o (rts_n)
    );

    assign loop_cts = loop_en & rts_bit;

    // R9: no looped value leaves outside loopback
    p_no_cts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |-> !loop_cts);

    // R8: without FIFO enable the level cannot hold the pin high
    p_fifo_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!fifo_en && !loop_en && rts_bit)) |-> !rts_n);

endmodule

// File: tb/sim_rts_flow_ctrl.sv
`timescale 1ns/1ps
module sim_rts_flow_ctrl;

    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int A_MCR = 'h10;
    localparam int A_SHD = 'h24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             auto_flow_en = 1'b0;
    logic             fifo_en = 1'b0;
    logic             trig_sel = 1'b0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] rx_thresh = '0;
    logic             loop_en = 1'b0;
    logic             rts_n;
    logic             loop_cts;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R4";

    int m_rts = 0;
    int m_pin = 1;

    always #4 clk = ~clk;

    rts_flow_ctrl #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .auto_flow_en(auto_flow_en), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .rx_level(rx_level), .rx_thresh(rx_thresh), .loop_en(loop_en),
        .rts_n(rts_n), .loop_cts(loop_cts)
    );

    task automatic check(string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t",
                     cur_req, what, act, exp, $time);
        end
    endtask

    // reference model: evaluated at each edge on the pre-edge inputs
    always @(posedge clk) begin
        int over;
        int nxt;
        if (!rst_n) begin
            m_rts = 0;
            m_pin = 1;
        end else begin
            over = trig_sel ? (int'(rx_level) >= DEPTH - 2)
                            : (int'(rx_level) > int'(rx_thresh));
            if (loop_en)                                   nxt = 1;
            else if (m_rts == 0)                           nxt = 1;
            else if (auto_flow_en && fifo_en && over != 0) nxt = 1;
            else                                           nxt = 0;
            m_pin = nxt;
            if (reg_wr && reg_addr == A_SHD)      m_rts = reg_wdata[0];
            else if (reg_wr && reg_addr == A_MCR) m_rts = reg_wdata[1];
        end
        #2;
        if (!done) begin
            longint exp_rd;
            exp_rd = (reg_addr == A_SHD) ? longint'(m_rts)
                   : (reg_addr == A_MCR) ? longint'(m_rts) << 1 : 0;
            check("rts_n", rts_n, m_pin);
            check("reg_rdata", reg_rdata, exp_rd);
            check("loop_cts", loop_cts, (loop_en && m_rts != 0) ? 1 : 0);
        end
    end

    task automatic wr(int addr, logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'(addr); reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sweep();
        for (int l = 0; l <= DEPTH; l++) begin
            @(negedge clk); rx_level = LVL_W'(l);
        end
        for (int l = DEPTH; l >= 0; l--) begin
            @(negedge clk); rx_level = LVL_W'(l);
        end
        idle(2);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #20000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        cur_req = "R4";
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        cur_req = "R1";
        reg_addr = 8'(A_SHD);
        wr(A_SHD, 32'h1);
        idle(2);
        reg_addr = 8'(A_MCR);
        idle(2);
        cur_req = "R5";
        wr(A_SHD, 32'h0);
        idle(2);
        wr(A_SHD, 32'h1);
        idle(2);
        cur_req = "R3";
        reg_addr = 8'(A_SHD);
        wr(A_SHD, 32'hFFFF_FFFE);
        idle(2);
        wr(A_SHD, 32'hFFFF_FFFF);
        idle(2);
        reg_addr = 8'h30;
        idle(2);
        cur_req = "R2";
        wr(A_MCR, 32'hFFFF_FFFD);
        reg_addr = 8'(A_SHD);
        idle(2);
        wr(A_MCR, 32'h0000_0002);
        idle(2);
        cur_req = "R6";
        @(negedge clk);
        auto_flow_en = 1'b1; fifo_en = 1'b1; trig_sel = 1'b0;
        rx_thresh = LVL_W'(5);
        sweep();
        cur_req = "R7";
        @(negedge clk); trig_sel = 1'b1;
        sweep();
        cur_req = "R10";
        @(negedge clk); rx_level = LVL_W'(DEPTH - 2);
        @(negedge clk); rx_level = LVL_W'(DEPTH - 3);
        idle(3);
        cur_req = "R8";
        @(negedge clk); fifo_en = 1'b0; rx_level = LVL_W'(DEPTH);
        idle(3);
        @(negedge clk); fifo_en = 1'b1;
        idle(2);
        cur_req = "R9";
        @(negedge clk); loop_en = 1'b1; rx_level = '0;
        idle(3);
        wr(A_SHD, 32'h0);
        idle(2);
        wr(A_SHD, 32'h1);
        @(negedge clk); loop_en = 1'b0;
        idle(3);
        cur_req = "R4";
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        finish_run();
    end

endmodule